// File: doc/BRIEF.md
# Load/Store Issue Timing Controller

This block sits in the issue stage of an in-order pipeline. It decides how many cycles a single-register load, store or preload occupies the issue slot, and how many memory beats it needs. A decoder presents one descriptor at a time. The descriptor carries:

- the kind of access: load, store, preload, or load into the program counter;
- the destination or data register, the base register and the offset register;
- the addressing-mode shape: pre-indexed or not, register offset, negative offset, left shift and shift amount;
- the writeback flag;
- a flag saying the address may be unaligned, and the unaligned-support enable.

The block answers with an accept strobe, a busy signal that holds the following instruction back, and a one-cycle memory request that carries the beat count.

The block also keeps a per-register countdown scoreboard. It records when the loaded data and the updated base register can be consumed. Base and offset registers are needed at the very start of issue, so a later instruction is stalled with a hazard while either of them is still counting down. A store's data register is read late, at the end of its issue. It therefore never causes a hazard. Instead, the block emits a sampling strobe naming that register in the cycle the store's issue completes.

Loads into the program counter cost one cycle when the return prediction was right. They cost a fixed longer penalty when it was wrong.

Top module: `ls_issue_timer`

## Requirements
- R1: A simple access issues in one cycle. "Simple" means any access that is not complex under R2 and has no unaligned split under R3. When accepted in cycle 0, busy stays low in cycle 1.
- R2: An access is complex when it is pre-indexed (req_pre_index=1), uses a register offset (req_use_off=1), and has any of the following: a negative offset (req_neg_off=1), a shift that is not a left shift (req_shift_lsl=0), or a left shift amount greater than 3. A complex access adds two issue cycles. A left shift of 0 to 3, a positive offset, or post-indexing keeps the access simple.
- R3: When req_unal_en=1 and req_maybe_unal=1, the access adds one issue cycle and needs 2 memory beats instead of 1. This applies even if the final address turns out to be aligned. mem_go pulses in the cycle after acceptance, with mem_beats holding 1 or 2.
- R4: With req_unal_en=0, req_maybe_unal has no effect: the issue cycles and mem_beats are those of the aligned case.
- R5: Let N be the issue-cycle count. Take a load (req_load=1, req_preload=0, req_to_pc=0) accepted in cycle 0 with destination req_rt. A later request naming that register as its base sees hazard high in cycles 1..N and low from cycle N+1.
- R6: With req_writeback=1, the base register becomes hazard-free from cycle N. It is free from cycle 1 when N=1. If the destination and the base are the same register, the later of the two ready times applies.
- R7: A preload, a store (req_load=0, req_preload=0) or a load into the program counter creates no scoreboard entry for req_rt.
- R8: A store's req_rt is never checked for a hazard. st_sample pulses in cycle N after a store accepted in cycle 0, with st_sample_reg equal to that store's req_rt.
- R9: A load into the program counter issues in 1 cycle when req_pred_ok=1 and in MISPRED_CYC (default 9) cycles otherwise. It always uses 1 memory beat, and the unaligned flags are ignored for it.
- R10: req_accept = req_valid and not busy and not hazard. After acceptance, busy is high for exactly N-1 cycles.
- R11: hazard is high when req_valid=1 and either the base register is pending, or req_use_off=1 and the offset register is pending. A pending offset register is ignored when req_use_off=0.
- R12: A synchronous active-high reset clears busy, mem_go, st_sample and every scoreboard countdown, even in the middle of a long issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor present |
| req_load | input | 1 | 1 = load, 0 = store |
| req_preload | input | 1 | Preload hint (load timing, no destination) |
| req_to_pc | input | 1 | Load into the program counter |
| req_pred_ok | input | 1 | Return/branch prediction was correct |
| req_rt | input | RIDX_W | Destination (load) or data (store) register |
| req_base | input | RIDX_W | Base register |
| req_off_reg | input | RIDX_W | Offset register |
| req_use_off | input | 1 | Register offset in use |
| req_pre_index | input | 1 | Pre-indexed addressing |
| req_neg_off | input | 1 | Offset is subtracted |
| req_shift_lsl | input | 1 | Offset shift is a left shift |
| req_shift_amt | input | 5 | Offset shift amount |
| req_writeback | input | 1 | Base register is updated |
| req_maybe_unal | input | 1 | Address may be unaligned |
| req_unal_en | input | 1 | Unaligned support enabled |
| req_accept | output | 1 | Descriptor accepted this cycle |
| busy | output | 1 | Issue slot occupied by the current access |
| hazard | output | 1 | Base or offset register not yet ready |
| mem_go | output | 1 | Memory request pulse |
| mem_beats | output | 2 | Beats for the request (1 or 2) |
| st_sample | output | 1 | Store data register sampled now |
| st_sample_reg | output | RIDX_W | Register sampled by st_sample |

## Verification
The bench targets the boundary between the simple and complex addressing shapes. It drives left shifts of 3 and 4, a non-left shift, and a negative post-indexed offset. A design that misjudges the boundary produces the wrong busy length.

It also checks that a potentially unaligned access is split only when unaligned support is enabled, and never for a load into the program counter. A wrong split shows up as the wrong beat count or the wrong busy length.

It measures the data-ready and base-ready cycles to the exact cycle, including the case where the destination and the base are the same register. An off-by-one scoreboard releases a consumer one cycle early or late.

Finally, it confirms three further behaviours:
- a store whose data register is still pending issues without a stall;
- an unused offset register never raises a hazard;
- a reset in the middle of a nine-cycle mispredict penalty leaves nothing pending.

// File: rtl/ls_timing_pkg.sv
package ls_timing_pkg;

  localparam int unsigned SHAMT_W = 5;

  typedef struct packed {
    logic               load;
    logic               preload;
    logic               to_pc;
    logic               pred_ok;
    logic               pre_index;
    logic               use_off;
    logic               neg_off;
    logic               shift_lsl;
    logic [SHAMT_W-1:0] shift_amt;
    logic               writeback;
    logic               maybe_unal;
    logic               unal_en;
  } ls_mode_t;

endpackage

// File: rtl/ls_cost_calc.sv
module ls_cost_calc
  import ls_timing_pkg::*;
#(
  parameter int unsigned CNT_W          = 4,
  parameter int unsigned MISPRED_CYC    = 9,
  parameter int unsigned FAST_SHIFT_MAX = 3
) (
  input  ls_mode_t         mode,
  output logic [CNT_W-1:0] issue_cyc,
  output logic [1:0]       beats
);

  localparam logic [SHAMT_W-1:0] FAST_LIM = SHAMT_W'(FAST_SHIFT_MAX);

  logic complex_mode;
  logic split;

  always_comb begin
    complex_mode = mode.pre_index & mode.use_off &
                   (mode.neg_off | ~mode.shift_lsl | (mode.shift_amt > FAST_LIM));
    split        = mode.unal_en & mode.maybe_unal & ~mode.to_pc;
    if (mode.to_pc)
      issue_cyc = mode.pred_ok ? CNT_W'(1) : CNT_W'(MISPRED_CYC);
    else
      issue_cyc = CNT_W'(1) + (complex_mode ? CNT_W'(2) : '0) + (split ? CNT_W'(1) : '0);
    beats = split ? 2'd2 : 2'd1;
  end

endmodule

// File: rtl/ls_busy_ctr.sv
module ls_busy_ctr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load_en)   cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy = (cnt_q != '0);
  assign last = (cnt_q == CNT_W'(1));

  assert_load_when_idle_R10: assert property (@(posedge clk) disable iff (rst)
    load_en |-> (cnt_q == '0));
  assert_countdown_R10: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - CNT_W'(1))));

endmodule

// File: rtl/ls_scoreboard.sv
module ls_scoreboard #(
  parameter int unsigned REG_N  = 16,
  parameter int unsigned RIDX_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_d,
  input  logic [RIDX_W-1:0] d_idx,
  input  logic [CNT_W-1:0]  d_val,
  input  logic              set_b,
  input  logic [RIDX_W-1:0] b_idx,
  input  logic [CNT_W-1:0]  b_val,
  input  logic [RIDX_W-1:0] chk_a,
  input  logic [RIDX_W-1:0] chk_b,
  input  logic              chk_b_en,
  output logic              pend
);

  logic [CNT_W-1:0] cnt_q [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_ent
    logic [CNT_W-1:0] nxt;
    logic             hit_d, hit_b;

    always_comb begin
      hit_d = set_d && (d_idx == RIDX_W'(g));
      hit_b = set_b && (b_idx == RIDX_W'(g));
      nxt   = (cnt_q[g] != '0) ? cnt_q[g] - CNT_W'(1) : '0;
      if (hit_d && d_val > nxt) nxt = d_val;
      if (hit_b && b_val > nxt) nxt = b_val;
    end

    always_ff @(posedge clk) begin
      if (rst) cnt_q[g] <= '0;
      else     cnt_q[g] <= nxt;
    end

    assert_sb_decay_R5: assert property (@(posedge clk) disable iff (rst)
      ((cnt_q[g] != '0) && !hit_d && !hit_b) |=>
        (cnt_q[g] == CNT_W'($past(cnt_q[g]) - CNT_W'(1))));
  end

  assign pend = (cnt_q[chk_a] != '0) | (chk_b_en & (cnt_q[chk_b] != '0));

endmodule

// File: rtl/ls_issue_timer.sv
module ls_issue_timer
  import ls_timing_pkg::*;
#(
  parameter int unsigned REG_N          = 16,
  parameter int unsigned MISPRED_CYC    = 9,
  parameter int unsigned FAST_SHIFT_MAX = 3,
  localparam int unsigned RIDX_W        = $clog2(REG_N),
  localparam int unsigned CNT_W         = $clog2(MISPRED_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_load,
  input  logic              req_preload,
  input  logic              req_to_pc,
  input  logic              req_pred_ok,
  input  logic [RIDX_W-1:0] req_rt,
  input  logic [RIDX_W-1:0] req_base,
  input  logic [RIDX_W-1:0] req_off_reg,
  input  logic              req_use_off,
  input  logic              req_pre_index,
  input  logic              req_neg_off,
  input  logic              req_shift_lsl,
  input  logic [4:0]        req_shift_amt,
  input  logic              req_writeback,
  input  logic              req_maybe_unal,
  input  logic              req_unal_en,
  output logic              req_accept,
  output logic              busy,
  output logic              hazard,
  output logic              mem_go,
  output logic [1:0]        mem_beats,
  output logic              st_sample,
  output logic [RIDX_W-1:0] st_sample_reg
);

  ls_mode_t         mode;
  logic [CNT_W-1:0] n_cyc;
  logic [1:0]       n_beats;
  logic             sb_pend, last, is_store, set_d, st_fire;
  logic             st_pend_q;

  always_comb begin
    mode.load       = req_load;
    mode.preload    = req_preload;
    mode.to_pc      = req_to_pc;
    mode.pred_ok    = req_pred_ok;
    mode.pre_index  = req_pre_index;
    mode.use_off    = req_use_off;
    mode.neg_off    = req_neg_off;
    mode.shift_lsl  = req_shift_lsl;
    mode.shift_amt  = req_shift_amt;
    mode.writeback  = req_writeback;
    mode.maybe_unal = req_maybe_unal;
    mode.unal_en    = req_unal_en;
  end

  ls_cost_calc #(.CNT_W(CNT_W), .MISPRED_CYC(MISPRED_CYC), .FAST_SHIFT_MAX(FAST_SHIFT_MAX)) i_cost (
    .mode(mode), .issue_cyc(n_cyc), .beats(n_beats));

  assign hazard     = req_valid & sb_pend;
  assign req_accept = req_valid & ~busy & ~sb_pend;
  assign is_store   = ~req_load & ~req_preload;
  assign set_d      = req_accept & req_load & ~req_preload & ~req_to_pc;

  ls_busy_ctr #(.CNT_W(CNT_W)) i_busy (
    .clk(clk), .rst(rst), .load_en(req_accept),
    .load_val(n_cyc - CNT_W'(1)), .busy(busy), .last(last));

  ls_scoreboard #(.REG_N(REG_N), .RIDX_W(RIDX_W), .CNT_W(CNT_W)) i_sb (
    .clk(clk), .rst(rst),
    .set_d(set_d), .d_idx(req_rt), .d_val(n_cyc),
    .set_b(req_accept & req_writeback), .b_idx(req_base), .b_val(n_cyc - CNT_W'(1)),
    .chk_a(req_base), .chk_b(req_off_reg), .chk_b_en(req_use_off), .pend(sb_pend));

  assign st_fire = (req_accept & is_store & (n_cyc == CNT_W'(1))) | (st_pend_q & last);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_go        <= 1'b0;
      mem_beats     <= 2'd0;
      st_pend_q     <= 1'b0;
      st_sample     <= 1'b0;
      st_sample_reg <= '0;
    end else begin
      mem_go    <= req_accept;
      mem_beats <= req_accept ? n_beats : 2'd0;
      st_sample <= st_fire;
      if (req_accept & is_store) st_sample_reg <= req_rt;
      if (req_accept & is_store & (n_cyc != CNT_W'(1))) st_pend_q <= 1'b1;
      else if (last)                                     st_pend_q <= 1'b0;
    end
  end

  assert_beats_pair_R3: assert property (@(posedge clk) disable iff (rst)
    mem_go |-> (mem_beats == 2'd1 || mem_beats == 2'd2));
  assert_split_cost_R3: assert property (@(posedge clk) disable iff (rst)
    (req_accept && !req_to_pc && req_unal_en && req_maybe_unal) |=> busy);
  assert_pc_single_beat_R9: assert property (@(posedge clk) disable iff (rst)
    (req_accept && req_to_pc) |=> (mem_beats == 2'd1));
  assert_st_after_issue_R8: assert property (@(posedge clk) disable iff (rst)
    st_sample |-> !busy);
  assert_reset_clear_R12: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !mem_go && !st_sample));

endmodule

// File: tb/test_ls_issue_timer.sv
module test_ls_issue_timer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       req_valid, req_load, req_preload, req_to_pc, req_pred_ok;
  logic [3:0] req_rt, req_base, req_off_reg;
  logic       req_use_off, req_pre_index, req_neg_off, req_shift_lsl;
  logic [4:0] req_shift_amt;
  logic       req_writeback, req_maybe_unal, req_unal_en;
  logic       req_accept, busy, hazard, mem_go, st_sample;
  logic [1:0] mem_beats;
  logic [3:0] st_sample_reg;

  ls_issue_timer i_ls_issue_timer (.*);

  typedef struct packed {
    logic ld, pf, pc, pok, pre, uoff, neg, lsl;
    logic [4:0] amt;
    logic wb, mu, ue;
    logic [3:0] n;
    logic [1:0] bt;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VT [NV] = '{
    //     ld   pf   pc   pok  pre  uoff neg  lsl  amt  wb   mu   ue   n  bt
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b0,1'b0,1'b0,4'd1,2'd1}, // R1 immediate
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,5'd2,1'b1,1'b0,1'b0,4'd1,2'd1}, // R2 lsl2 simple
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,5'd3,1'b0,1'b0,1'b0,4'd1,2'd1}, // R2 lsl3 simple
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,5'd0,1'b1,1'b0,1'b0,4'd3,2'd1}, // R2 negative
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,5'd4,1'b0,1'b0,1'b0,4'd3,2'd1}, // R2 lsl4
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,5'd1,1'b1,1'b0,1'b0,4'd3,2'd1}, // R2 non-left shift
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,5'd0,1'b1,1'b0,1'b0,4'd1,2'd1}, // R2 post-index neg
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b1,1'b1,1'b1,4'd2,2'd2}, // R3 split
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,1'b1,5'd0,1'b1,1'b1,1'b1,4'd4,2'd2}, // R3 complex+split
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b1,1'b1,1'b0,4'd1,2'd1}, // R4 support off
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b1,1'b0,1'b0,4'd1,2'd1}, // R8 store simple
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,5'd2,1'b0,1'b1,1'b1,4'd4,2'd2}, // R8 store long
    '{1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b0,1'b1,1'b1,4'd2,2'd2}, // R7 preload
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,5'd0,1'b1,1'b0,1'b0,4'd1,2'd1}, // R9 predicted
    '{1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,5'd0,1'b0,1'b0,1'b0,4'd9,2'd1}, // R9 mispredicted
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,5'd0,1'b1,1'b1,1'b1,4'd9,2'd1}, // R9 ignores split
    '{1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,5'd1,1'b0,1'b1,1'b1,4'd2,2'd2}  // R3 lsl1 split
  };

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_req();
    req_valid = 0; req_load = 1; req_preload = 0; req_to_pc = 0; req_pred_ok = 1;
    req_rt = 15; req_base = 0; req_off_reg = 0; req_use_off = 0; req_pre_index = 1;
    req_neg_off = 0; req_shift_lsl = 1; req_shift_amt = 0; req_writeback = 0;
    req_maybe_unal = 0; req_unal_en = 0;
  endtask

  task automatic drive_vec(input vec_t v, input logic [3:0] rt, input logic [3:0] bs);
    req_valid = 1; req_load = v.ld; req_preload = v.pf; req_to_pc = v.pc; req_pred_ok = v.pok;
    req_rt = rt; req_base = bs; req_off_reg = 6; req_use_off = v.uoff; req_pre_index = v.pre;
    req_neg_off = v.neg; req_shift_lsl = v.lsl; req_shift_amt = v.amt; req_writeback = v.wb;
    req_maybe_unal = v.mu; req_unal_en = v.ue;
  endtask

  task automatic probe(input logic [3:0] bs);
    idle_req();
    req_valid = 1; req_base = bs; req_rt = 14;
  endtask

  task automatic wait_idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Issue v in cycle 0, then probe register pb from cycle 1 until the probe is accepted.
  task automatic issue_probe(input vec_t v, input logic [3:0] rt, input logic [3:0] bs,
                             input logic [3:0] pb, input int idx,
                             output int bc, output int rdy, output int stk,
                             output int streg);
    bc = 0; rdy = 0; stk = 0; streg = 0;
    @(negedge clk);
    drive_vec(v, rt, bs);
    #1;
    chk(req_accept == 1'b1, $sformatf("R10 accept vector %0d", idx), int'(req_accept), 1);
    @(negedge clk);
    probe(pb);
    for (int k = 1; k <= 25; k++) begin
      #1;
      if (k == 1) begin
        chk(mem_go == 1'b1, $sformatf("R3 mem_go vector %0d", idx), int'(mem_go), 1);
        chk(mem_beats == v.bt, $sformatf("R3/R4/R9 beats vector %0d", idx),
            int'(mem_beats), int'(v.bt));
      end
      if (busy) bc++;
      if (!hazard && rdy == 0) rdy = k;
      if (st_sample) begin stk = k; streg = int'(st_sample_reg); end
      if (req_accept) break;
      @(negedge clk);
    end
    @(negedge clk);
    idle_req();
    wait_idle(12);
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int bc, rdy, stk, streg, expd, expb;
    idle_req();
    wait_idle(3);
    rst = 0;
    @(negedge clk);
    #1;
    // R12 reset state
    chk(busy == 0, "R12 busy after reset", int'(busy), 0);
    chk(mem_go == 0, "R12 mem_go after reset", int'(mem_go), 0);
    chk(st_sample == 0, "R12 st_sample after reset", int'(st_sample), 0);
    probe(3);
    #1;
    chk(hazard == 0, "R12 no pending entry after reset", int'(hazard), 0);
    idle_req();
    wait_idle(3);

    for (int i = 0; i < NV; i++) begin
      // data probe on rt=3
      issue_probe(VT[i], 3, 5, 3, i, bc, rdy, stk, streg);
      chk(bc == int'(VT[i].n) - 1, $sformatf("R1/R2/R3/R9/R10 busy cycles vector %0d", i),
          bc, int'(VT[i].n) - 1);
      expd = (VT[i].ld && !VT[i].pf && !VT[i].pc) ? int'(VT[i].n) + 1 : 1;
      chk(rdy == expd, $sformatf("R5/R7 data ready vector %0d", i), rdy, expd);
      if (!VT[i].ld && !VT[i].pf) begin
        chk(stk == int'(VT[i].n), $sformatf("R8 sample cycle vector %0d", i), stk, int'(VT[i].n));
        chk(streg == 3, $sformatf("R8 sample reg vector %0d", i), streg, 3);
      end else begin
        chk(stk == 0, $sformatf("R8 no sample for load vector %0d", i), stk, 0);
      end
      // base probe on base=5
      issue_probe(VT[i], 3, 5, 5, i, bc, rdy, stk, streg);
      expb = VT[i].wb ? int'(VT[i].n) : 1;
      chk(rdy == expb, $sformatf("R6 base ready vector %0d", i), rdy, expb);
    end

    // R6 same destination and base: later time (data, N+1=5) wins
    issue_probe(VT[8], 5, 5, 5, 100, bc, rdy, stk, streg);
    chk(rdy == 5, "R6 shared register ready", rdy, 5);

    // R11 offset hazard only when offset used
    @(negedge clk);
    drive_vec(VT[0], 3, 5);
    @(negedge clk);
    idle_req();
    req_valid = 1; req_base = 8; req_off_reg = 3; req_use_off = 1; req_pre_index = 0;
    #1;
    chk(hazard == 1, "R11 pending offset raises hazard", int'(hazard), 1);
    chk(req_accept == 0, "R11 pending offset blocks accept", int'(req_accept), 0);
    req_use_off = 0;
    #1;
    chk(hazard == 0, "R11 unused offset ignored", int'(hazard), 0);
    @(negedge clk);
    idle_req();
    wait_idle(12);

    // R8 store data register is late: pending rt does not stall
    @(negedge clk);
    drive_vec(VT[0], 3, 5);
    @(negedge clk);
    drive_vec(VT[10], 3, 9);
    req_writeback = 0;
    #1;
    chk(hazard == 0, "R8 store data reg no hazard", int'(hazard), 0);
    chk(req_accept == 1, "R8 store accepted with pending data reg", int'(req_accept), 1);
    @(negedge clk);
    idle_req();
    #1;
    chk(st_sample == 1 && st_sample_reg == 3, "R8 late sample strobe", int'(st_sample), 1);
    wait_idle(12);

    // R12 reset during a long mispredict penalty
    @(negedge clk);
    drive_vec(VT[15], 3, 5);
    @(negedge clk);
    idle_req();
    @(negedge clk);
    #1;
    chk(busy == 1, "R9 busy during penalty", int'(busy), 1);
    rst = 1;
    @(negedge clk);
    rst = 0;
    #1;
    chk(busy == 0, "R12 busy cleared mid-issue", int'(busy), 0);
    probe(5);
    #1;
    chk(hazard == 0, "R12 base entry cleared", int'(hazard), 0);
    @(negedge clk);
    idle_req();
    wait_idle(4);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule